// File: doc/BRIEF.md
# Reconfigurable-Width Vector Register File

This block holds the architectural vector state of a vector unit. Thirty-two vector registers share one fixed pool of 2048 bits each. A width register sets how that pool is split into elements: 32 elements of 64 bits, 64 elements of 32 bits, or 128 elements of 16 bits. Beside the vector storage sit 32 one-bit-per-element flag registers that can act as write masks, a vector length register that limits which element positions a write may touch, and sixteen 32-bit control registers.

The datapath uses the element ports. Two independent read ports take a register number and an element index and return the element zero-extended to 64 bits one cycle later. One write port takes a register number, element index and data, and can optionally be gated by a chosen flag register. Flags have their own write port and a registered read port. All ports are plain strobed interfaces with no back-pressure: a write strobe is acted on in the cycle it is high, and a read address is always accepted, with its result one cycle later.

Top module: `vec_regfile`

## Requirements
- R1: Element k at element width w occupies bits k*w through k*w+w-1 of its register's 2048 bits. A change of width keeps the stored bits, so data written at one width can be read back, re-partitioned, at another width.
- R2: The flag file has 32 registers of 128 bits and is all zero after reset. A flag write (register, index, bit) takes effect at the next clock edge. The flag read port returns the addressed bit one cycle after the address is presented.
- R3: The width code means 0 = 64-bit, 1 = 32-bit, 2 = 16-bit elements and is 0 after reset. A write of code 3 is ignored and the previous width is kept.
- R4: The vector length is 32 after reset. A written length above the element count of the current width (32, 64 or 128) is stored as that count. When the width changes, a stored length above the new element count is lowered to that count.
- R5: An element write whose index is equal to or above the current vector length is dropped, and the register keeps its contents.
- R6: A masked element write commits only when the selected flag register holds 1 at the write's element index, taking the flag value from before any flag write in the same cycle. An unmasked write ignores the flags.
- R7: Each of the two read ports returns the addressed element zero-extended to 64 bits, one cycle after the address is presented. An index at or above the element count of the current width reads as 0.
- R8: When a read and a write address the same element in the same cycle, the read returns the value from before the write. The new value is seen from the next read.
- R9: The 16 control registers are 32 bits wide and zero after reset. A write takes effect at the next edge, and the control read port returns the addressed register one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_we | input | 1 | Load the element width code |
| width_code | input | 2 | New width code (0:64, 1:32, 2:16) |
| vl_we | input | 1 | Load the vector length |
| vl_val | input | 8 | Requested vector length |
| cur_width | output | 2 | Current width code |
| cur_vlen | output | 8 | Current vector length |
| wr_en | input | 1 | Element write strobe |
| wr_masked | input | 1 | Gate the write with a flag register |
| wr_flag_sel | input | 5 | Flag register used as the mask |
| wr_vreg | input | 5 | Destination vector register |
| wr_idx | input | 7 | Destination element index |
| wr_data | input | 64 | Write data; low w bits are stored |
| ra_vreg | input | 5 | Read port A register |
| ra_idx | input | 7 | Read port A element index |
| ra_data | output | 64 | Read port A data, zero-extended |
| rb_vreg | input | 5 | Read port B register |
| rb_idx | input | 7 | Read port B element index |
| rb_data | output | 64 | Read port B data, zero-extended |
| fw_en | input | 1 | Flag write strobe |
| fw_reg | input | 5 | Flag register to write |
| fw_idx | input | 7 | Flag bit index to write |
| fw_bit | input | 1 | Flag value |
| fr_reg | input | 5 | Flag register to read |
| fr_idx | input | 7 | Flag bit index to read |
| fr_bit | output | 1 | Flag read result |
| cw_en | input | 1 | Control register write strobe |
| cw_addr | input | 4 | Control register write address |
| cw_data | input | 32 | Control register write data |
| cr_addr | input | 4 | Control register read address |
| cr_data | output | 32 | Control register read result |

## Verification
The bench builds the block with its default parameters: 32 registers of 2048 bits, elements from 64 down to 16 bits in four 16-bit lanes, 16 control registers. With these values all three widths are in reach, including the last element of each partition (index 31, 63 and 127), the clamp of the vector length at each of the three element counts, and the reading of one 64-bit element as two 32-bit and four 16-bit elements. Flag indices up to 127 and the highest register number are reachable as well, so masking and dropped writes are checked at real boundaries rather than at scaled-down ones.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  typedef enum logic [1:0] {
    VW_64  = 2'd0,
    VW_32  = 2'd1,
    VW_16  = 2'd2,
    VW_RSV = 2'd3
  } vrf_width_e;
endpackage

// File: rtl/vrf_lane_bank.sv
// One 16-bit slice of every 64-bit word of the vector storage.
module vrf_lane_bank #(
  parameter int DEPTH = 1024,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr_a,
  output logic [W-1:0]             rdata_a,
  input  logic [$clog2(DEPTH)-1:0] raddr_b,
  output logic [W-1:0]             rdata_b
);
  logic [W-1:0] mem [DEPTH];

  // Non-blocking update: a same-cycle read sees the old contents.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/vrf_elem_map.sv
// Maps (width code, element index) onto a storage word and the lanes it covers.
module vrf_elem_map #(
  parameter int LANES   = 4,
  parameter int WORDS   = 32,
  parameter int EIDX_W  = 7,
  parameter int WORD_AW = 5,
  parameter int LANE_AW = 2
) (
  input  logic [1:0]         code,
  input  logic [EIDX_W-1:0]  idx,
  output logic [WORD_AW-1:0] word,
  output logic [LANE_AW-1:0] flane,
  output logic [LANES-1:0]   lmask,
  output logic               in_range
);
  always_comb begin
    int c, per, sub, wrd, lim;
    c        = int'(code);
    per      = LANES >> c;
    sub      = int'(idx) & ((1 << c) - 1);
    wrd      = int'(idx) >> c;
    lim      = WORDS << c;
    word     = WORD_AW'(wrd);
    flane    = LANE_AW'(sub * per);
    lmask    = LANES'(((1 << per) - 1) << (sub * per));
    in_range = int'(idx) < lim;
  end
endmodule

// File: rtl/vrf_flag_file.sv
module vrf_flag_file #(
  parameter int NREG  = 32,
  parameter int NBITS = 128,
  localparam int RA   = $clog2(NREG),
  localparam int IA   = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RA-1:0] wreg,
  input  logic [IA-1:0] widx,
  input  logic          wbit,
  input  logic [RA-1:0] rreg,
  input  logic [IA-1:0] ridx,
  output logic          rbit,
  input  logic [RA-1:0] mreg,
  input  logic [IA-1:0] midx,
  output logic          mbit
);
  logic [NBITS-1:0] flags [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) flags[r] <= '0;
      rbit <= 1'b0;
    end else begin
      if (we) flags[wreg][widx] <= wbit;
      rbit <= flags[rreg][ridx];
    end
  end

  // Mask lookup sees the flag value held before this cycle's flag write.
  assign mbit = flags[mreg][midx];

  assert_flag_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> flags[$past(wreg)][$past(widx)] == $past(wbit));
endmodule

// File: rtl/vrf_cfg.sv
// Width code, vector length and the scalar control registers.
module vrf_cfg #(
  parameter int NUM_CREGS = 16,
  parameter int CREG_W    = 32,
  parameter int WORDS     = 32,
  parameter int LANE_LG   = 2,
  parameter int VL_W      = 8,
  localparam int CR_AW    = $clog2(NUM_CREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              width_we,
  input  logic [1:0]        width_in,
  input  logic              vl_we,
  input  logic [VL_W-1:0]   vl_in,
  output logic [1:0]        width_q,
  output logic [VL_W-1:0]   vlen_q,
  input  logic              cr_we,
  input  logic [CR_AW-1:0]  cr_waddr,
  input  logic [CREG_W-1:0] cr_wdata,
  input  logic [CR_AW-1:0]  cr_raddr,
  output logic [CREG_W-1:0] cr_rdata
);
  import vrf_pkg::*;

  logic [1:0]        width_d;
  logic [VL_W-1:0]   vlen_d;
  logic [CREG_W-1:0] cregs [NUM_CREGS];
  int                cap_d, cap_now;

  always_comb begin
    logic [VL_W-1:0] cand;
    width_d = (width_we && int'(width_in) <= LANE_LG) ? width_in : width_q;
    cap_d   = WORDS << int'(width_d);
    cap_now = WORDS << int'(width_q);
    cand    = vl_we ? vl_in : vlen_q;
    vlen_d  = (int'(cand) > cap_d) ? VL_W'(cap_d) : cand;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= VW_64;
      vlen_q  <= VL_W'(WORDS);
    end else begin
      width_q <= width_d;
      vlen_q  <= vlen_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CREGS; i++) cregs[i] <= '0;
      cr_rdata <= '0;
    end else begin
      if (cr_we) cregs[cr_waddr] <= cr_wdata;
      cr_rdata <= cregs[cr_raddr];
    end
  end

  assert_width_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(width_q) <= LANE_LG);

  assert_vlen_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vlen_q) <= (WORDS << int'(width_q)));

  assert_vlen_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_we && !width_we && int'(vl_in) <= cap_now) |=> vlen_q == $past(vl_in));

  assert_creg_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |=> cregs[$past(cr_waddr)] == $past(cr_wdata));
endmodule

// File: rtl/vec_regfile.sv
module vec_regfile #(
  parameter int NUM_VREGS = 32,
  parameter int REG_BITS  = 2048,
  parameter int MAX_W     = 64,
  parameter int MIN_W     = 16,
  parameter int NUM_CREGS = 16,
  parameter int CREG_W    = 32,
  localparam int LANES     = MAX_W / MIN_W,
  localparam int LANE_AW   = $clog2(LANES),
  localparam int WORDS     = REG_BITS / MAX_W,
  localparam int WORD_AW   = $clog2(WORDS),
  localparam int MAX_ELEMS = REG_BITS / MIN_W,
  localparam int EIDX_W    = $clog2(MAX_ELEMS),
  localparam int VL_W      = $clog2(MAX_ELEMS + 1),
  localparam int VREG_AW   = $clog2(NUM_VREGS),
  localparam int DEPTH     = NUM_VREGS * WORDS,
  localparam int BANK_AW   = VREG_AW + WORD_AW,
  localparam int CR_AW     = $clog2(NUM_CREGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               width_we,
  input  logic [1:0]         width_code,
  input  logic               vl_we,
  input  logic [VL_W-1:0]    vl_val,
  output logic [1:0]         cur_width,
  output logic [VL_W-1:0]    cur_vlen,
  input  logic               wr_en,
  input  logic               wr_masked,
  input  logic [VREG_AW-1:0] wr_flag_sel,
  input  logic [VREG_AW-1:0] wr_vreg,
  input  logic [EIDX_W-1:0]  wr_idx,
  input  logic [MAX_W-1:0]   wr_data,
  input  logic [VREG_AW-1:0] ra_vreg,
  input  logic [EIDX_W-1:0]  ra_idx,
  output logic [MAX_W-1:0]   ra_data,
  input  logic [VREG_AW-1:0] rb_vreg,
  input  logic [EIDX_W-1:0]  rb_idx,
  output logic [MAX_W-1:0]   rb_data,
  input  logic               fw_en,
  input  logic [VREG_AW-1:0] fw_reg,
  input  logic [EIDX_W-1:0]  fw_idx,
  input  logic               fw_bit,
  input  logic [VREG_AW-1:0] fr_reg,
  input  logic [EIDX_W-1:0]  fr_idx,
  output logic               fr_bit,
  input  logic               cw_en,
  input  logic [CR_AW-1:0]   cw_addr,
  input  logic [CREG_W-1:0]  cw_data,
  input  logic [CR_AW-1:0]   cr_addr,
  output logic [CREG_W-1:0]  cr_data
);
  function automatic logic [MAX_W-1:0] elem_mask(input logic [1:0] c);
    return {MAX_W{1'b1}} >> (MAX_W - (MAX_W >> int'(c)));
  endfunction

  // ---------------- configuration and control registers ----------------
  vrf_cfg #(
    .NUM_CREGS(NUM_CREGS), .CREG_W(CREG_W), .WORDS(WORDS),
    .LANE_LG(LANE_AW), .VL_W(VL_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .width_we(width_we), .width_in(width_code),
    .vl_we(vl_we), .vl_in(vl_val),
    .width_q(cur_width), .vlen_q(cur_vlen),
    .cr_we(cw_en), .cr_waddr(cw_addr), .cr_wdata(cw_data),
    .cr_raddr(cr_addr), .cr_rdata(cr_data)
  );

  // ---------------- flag file ----------------
  logic mask_bit;

  vrf_flag_file #(.NREG(NUM_VREGS), .NBITS(MAX_ELEMS)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .we(fw_en), .wreg(fw_reg), .widx(fw_idx), .wbit(fw_bit),
    .rreg(fr_reg), .ridx(fr_idx), .rbit(fr_bit),
    .mreg(wr_flag_sel), .midx(wr_idx), .mbit(mask_bit)
  );

  // ---------------- element address mapping ----------------
  logic [WORD_AW-1:0] w_word, a_word, b_word;
  logic [LANE_AW-1:0] w_flane, a_flane, b_flane;
  logic [LANES-1:0]   w_lmask, a_lmask, b_lmask;
  logic               w_ok, a_ok, b_ok;

  vrf_elem_map #(.LANES(LANES), .WORDS(WORDS), .EIDX_W(EIDX_W),
                 .WORD_AW(WORD_AW), .LANE_AW(LANE_AW)) u_map_w (
    .code(cur_width), .idx(wr_idx), .word(w_word), .flane(w_flane),
    .lmask(w_lmask), .in_range(w_ok));

  vrf_elem_map #(.LANES(LANES), .WORDS(WORDS), .EIDX_W(EIDX_W),
                 .WORD_AW(WORD_AW), .LANE_AW(LANE_AW)) u_map_a (
    .code(cur_width), .idx(ra_idx), .word(a_word), .flane(a_flane),
    .lmask(a_lmask), .in_range(a_ok));

  vrf_elem_map #(.LANES(LANES), .WORDS(WORDS), .EIDX_W(EIDX_W),
                 .WORD_AW(WORD_AW), .LANE_AW(LANE_AW)) u_map_b (
    .code(cur_width), .idx(rb_idx), .word(b_word), .flane(b_flane),
    .lmask(b_lmask), .in_range(b_ok));

  // ---------------- write gating ----------------
  logic             wr_commit;
  logic [MAX_W-1:0] wr_shift;
  logic [LANES-1:0] lane_we;

  // w_ok is implied by the length clamp; kept as a second guard.
  assign wr_commit = wr_en && w_ok && (int'(wr_idx) < int'(cur_vlen))
                     && (!wr_masked || mask_bit);
  assign wr_shift  = wr_data << (int'(w_flane) * MIN_W);
  assign lane_we   = wr_commit ? w_lmask : '0;

  // ---------------- lane banks ----------------
  logic [MIN_W-1:0] a_lane [LANES];
  logic [MIN_W-1:0] b_lane [LANES];
  logic [MAX_W-1:0] a_word_q, b_word_q;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    vrf_lane_bank #(.DEPTH(DEPTH), .W(MIN_W)) u_bank (
      .clk(clk),
      .we(lane_we[j]),
      .waddr(BANK_AW'({wr_vreg, w_word})),
      .wdata(wr_shift[j*MIN_W +: MIN_W]),
      .raddr_a(BANK_AW'({ra_vreg, a_word})),
      .rdata_a(a_lane[j]),
      .raddr_b(BANK_AW'({rb_vreg, b_word})),
      .rdata_b(b_lane[j])
    );
    assign a_word_q[j*MIN_W +: MIN_W] = a_lane[j];
    assign b_word_q[j*MIN_W +: MIN_W] = b_lane[j];
  end

  // ---------------- read extraction ----------------
  logic [LANE_AW-1:0] a_flane_q, b_flane_q;
  logic [1:0]         a_code_q, b_code_q;
  logic               a_ok_q, b_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_flane_q <= '0; b_flane_q <= '0;
      a_code_q  <= '0; b_code_q  <= '0;
      a_ok_q    <= 1'b0; b_ok_q  <= 1'b0;
    end else begin
      a_flane_q <= a_flane; b_flane_q <= b_flane;
      a_code_q  <= cur_width; b_code_q <= cur_width;
      a_ok_q    <= a_ok;   b_ok_q    <= b_ok;
    end
  end

  assign ra_data = a_ok_q ? ((a_word_q >> (int'(a_flane_q) * MIN_W)) & elem_mask(a_code_q)) : '0;
  assign rb_data = b_ok_q ? ((b_word_q >> (int'(b_flane_q) * MIN_W)) & elem_mask(b_code_q)) : '0;

  assert_lane_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $countones(lane_we) == (LANES >> int'(cur_width)));

  assert_read_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(a_lmask) == (LANES >> int'(cur_width)));
endmodule

// File: tb/vec_regfile_bench.sv
`timescale 1ns/1ps
module vec_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        width_we = 0;
  logic [1:0]  width_code = 0;
  logic        vl_we = 0;
  logic [7:0]  vl_val = 0;
  logic [1:0]  cur_width;
  logic [7:0]  cur_vlen;
  logic        wr_en = 0, wr_masked = 0;
  logic [4:0]  wr_flag_sel = 0, wr_vreg = 0;
  logic [6:0]  wr_idx = 0;
  logic [63:0] wr_data = 0;
  logic [4:0]  ra_vreg = 0, rb_vreg = 0;
  logic [6:0]  ra_idx = 0, rb_idx = 0;
  logic [63:0] ra_data, rb_data;
  logic        fw_en = 0, fw_bit = 0;
  logic [4:0]  fw_reg = 0, fr_reg = 0;
  logic [6:0]  fw_idx = 0, fr_idx = 0;
  logic        fr_bit;
  logic        cw_en = 0;
  logic [3:0]  cw_addr = 0, cr_addr = 0;
  logic [31:0] cw_data = 0, cr_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  vec_regfile u_vec_regfile (
    .clk(clk), .rst_n(rst_n),
    .width_we(width_we), .width_code(width_code),
    .vl_we(vl_we), .vl_val(vl_val),
    .cur_width(cur_width), .cur_vlen(cur_vlen),
    .wr_en(wr_en), .wr_masked(wr_masked), .wr_flag_sel(wr_flag_sel),
    .wr_vreg(wr_vreg), .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_vreg(ra_vreg), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_vreg(rb_vreg), .rb_idx(rb_idx), .rb_data(rb_data),
    .fw_en(fw_en), .fw_reg(fw_reg), .fw_idx(fw_idx), .fw_bit(fw_bit),
    .fr_reg(fr_reg), .fr_idx(fr_idx), .fr_bit(fr_bit),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .cr_addr(cr_addr), .cr_data(cr_data)
  );

  // Table: {width[141:140], vreg[139:135], idx[134:128], data[127:64], expected[63:0]}
  localparam logic [141:0] TBL [8] = '{
    {2'd0, 5'd1,  7'd0,   64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},
    {2'd0, 5'd31, 7'd31,  64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210},
    {2'd1, 5'd2,  7'd0,   64'hAAAA_BBBB_CCCC_DDDD, 64'h0000_0000_CCCC_DDDD},
    {2'd1, 5'd2,  7'd63,  64'h1111_2222_3333_4444, 64'h0000_0000_3333_4444},
    {2'd2, 5'd5,  7'd0,   64'hFFFF_EEEE_DDDD_9999, 64'h0000_0000_0000_9999},
    {2'd2, 5'd5,  7'd127, 64'h0000_0000_0000_7777, 64'h0000_0000_0000_7777},
    {2'd2, 5'd5,  7'd1,   64'h1234_5678_9ABC_5A5A, 64'h0000_0000_0000_5A5A},
    {2'd1, 5'd2,  7'd1,   64'hFFFF_FFFF_8765_4321, 64'h0000_0000_8765_4321}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_width(input logic [1:0] c);
    @(negedge clk); width_we = 1; width_code = c;
    @(negedge clk); width_we = 0;
  endtask

  task automatic set_vl(input logic [7:0] v);
    @(negedge clk); vl_we = 1; vl_val = v;
    @(negedge clk); vl_we = 0;
  endtask

  task automatic write_el(input logic m, input logic [4:0] fs, input logic [4:0] r,
                          input logic [6:0] i, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_masked = m; wr_flag_sel = fs; wr_vreg = r; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 0; wr_masked = 0;
  endtask

  task automatic read_el(input logic [4:0] r, input logic [6:0] i,
                         output logic [63:0] a, output logic [63:0] b);
    @(negedge clk); ra_vreg = r; ra_idx = i; rb_vreg = r; rb_idx = i;
    @(posedge clk); #1; a = ra_data; b = rb_data;
  endtask

  task automatic write_flag(input logic [4:0] r, input logic [6:0] i, input logic v);
    @(negedge clk); fw_en = 1; fw_reg = r; fw_idx = i; fw_bit = v;
    @(negedge clk); fw_en = 0;
  endtask

  task automatic read_flag(input logic [4:0] r, input logic [6:0] i, output logic v);
    @(negedge clk); fr_reg = r; fr_idx = i;
    @(posedge clk); #1; v = fr_bit;
  endtask

  task automatic read_creg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); cr_addr = a;
    @(posedge clk); #1; v = cr_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1-all actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] a, b;
    logic        f;
    logic [31:0] c;

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state
    check("R3 reset width", 64'(cur_width), 64'd0);
    check("R4 reset vlen", 64'(cur_vlen), 64'd32);
    read_flag(5'd0, 7'd0, f);     check("R2 reset flag", 64'(f), 64'd0);
    read_flag(5'd31, 7'd127, f);  check("R2 reset flag high", 64'(f), 64'd0);
    read_creg(4'd0, c);           check("R9 reset creg", 64'(c), 64'd0);

    // Table walk: write at each width and read back on both ports (R1, R7)
    for (int n = 0; n < 8; n++) begin
      set_width(TBL[n][141:140]);
      set_vl(8'd128);
      write_el(1'b0, 5'd0, TBL[n][139:135], TBL[n][134:128], TBL[n][127:64]);
      read_el(TBL[n][139:135], TBL[n][134:128], a, b);
      check("R7 table port A", a, TBL[n][63:0]);
      check("R7 table port B", b, TBL[n][63:0]);
    end

    // Neighbours untouched by narrow writes (R1)
    set_width(2'd2);
    read_el(5'd5, 7'd0, a, b);  check("R1 16b neighbour kept", a, 64'h9999);
    set_width(2'd1);
    read_el(5'd2, 7'd0, a, b);  check("R1 32b neighbour kept", a, 64'hCCCC_DDDD);

    // Reinterpretation across widths (R1)
    set_width(2'd0);
    set_vl(8'd32);
    write_el(1'b0, 5'd0, 5'd3, 7'd1, 64'h4444_3333_2222_1111);
    set_width(2'd2);
    read_el(5'd3, 7'd4, a, b);  check("R1 16b view low", a, 64'h1111);
    read_el(5'd3, 7'd7, a, b);  check("R1 16b view high", a, 64'h4444);
    set_width(2'd1);
    read_el(5'd3, 7'd3, a, b);  check("R1 32b view upper", a, 64'h4444_3333);
    read_el(5'd3, 7'd2, a, b);  check("R1 32b view lower", b, 64'h2222_1111);

    // Length clamp and width legality (R4, R3)
    set_width(2'd2);
    set_vl(8'd200);  check("R4 clamp at 128", 64'(cur_vlen), 64'd128);
    set_vl(8'd50);   check("R4 in-range load", 64'(cur_vlen), 64'd50);
    set_width(2'd0); check("R4 reclamp to 32", 64'(cur_vlen), 64'd32);
    set_width(2'd1); check("R4 no raise on widen", 64'(cur_vlen), 64'd32);
    set_vl(8'd64);   check("R4 max at 32b", 64'(cur_vlen), 64'd64);
    set_vl(8'd65);   check("R4 clamp at 64", 64'(cur_vlen), 64'd64);
    set_width(2'd3); check("R3 reserved code ignored", 64'(cur_width), 64'd1);
    check("R3 vlen unchanged by reserved code", 64'(cur_vlen), 64'd64);

    // Writes beyond the vector length (R5)
    set_width(2'd0);
    set_vl(8'd32);
    write_el(1'b0, 5'd0, 5'd7, 7'd4, 64'h55);
    write_el(1'b0, 5'd0, 5'd7, 7'd3, 64'h33);
    set_vl(8'd4);
    write_el(1'b0, 5'd0, 5'd7, 7'd4, 64'hAA);
    write_el(1'b0, 5'd0, 5'd7, 7'd3, 64'hBB);
    read_el(5'd7, 7'd4, a, b);  check("R5 write at vlen dropped", a, 64'h55);
    read_el(5'd7, 7'd3, a, b);  check("R5 write below vlen kept", a, 64'hBB);

    // Flags and masked writes (R2, R6)
    set_vl(8'd32);
    write_flag(5'd2, 7'd5, 1'b1);
    read_flag(5'd2, 7'd5, f);   check("R2 flag set", 64'(f), 64'd1);
    read_flag(5'd2, 7'd6, f);   check("R2 other flag clear", 64'(f), 64'd0);
    write_el(1'b0, 5'd0, 5'd9, 7'd5, 64'h11);
    write_el(1'b0, 5'd0, 5'd9, 7'd6, 64'h22);
    write_el(1'b1, 5'd2, 5'd9, 7'd5, 64'h99);
    write_el(1'b1, 5'd2, 5'd9, 7'd6, 64'h88);
    read_el(5'd9, 7'd5, a, b);  check("R6 masked write flag=1", a, 64'h99);
    read_el(5'd9, 7'd6, a, b);  check("R6 masked write flag=0", a, 64'h22);
    write_el(1'b0, 5'd2, 5'd9, 7'd6, 64'h77);
    read_el(5'd9, 7'd6, a, b);  check("R6 unmasked ignores flag", a, 64'h77);

    // Masked write sees flag from before a same-cycle flag write (R6)
    @(negedge clk);
    fw_en = 1; fw_reg = 5'd2; fw_idx = 7'd6; fw_bit = 1'b1;
    wr_en = 1; wr_masked = 1; wr_flag_sel = 5'd2; wr_vreg = 5'd9; wr_idx = 7'd6; wr_data = 64'h66;
    @(negedge clk); fw_en = 0; wr_en = 0; wr_masked = 0;
    read_el(5'd9, 7'd6, a, b);  check("R6 old flag used", a, 64'h77);

    // Read during write of the same element (R8)
    @(negedge clk);
    ra_vreg = 5'd9; ra_idx = 7'd5;
    wr_en = 1; wr_vreg = 5'd9; wr_idx = 7'd5; wr_data = 64'hCAFE;
    @(posedge clk); #1;
    check("R8 same-cycle read old", ra_data, 64'h99);
    @(negedge clk); wr_en = 0;
    @(posedge clk); #1;
    check("R8 next read new", ra_data, 64'hCAFE);

    // Index outside the width's partition reads zero (R7)
    read_el(5'd1, 7'd40, a, b);
    check("R7 out-of-range port A", a, 64'd0);
    check("R7 out-of-range port B", b, 64'd0);

    // Control registers (R9)
    @(negedge clk); cw_en = 1; cw_addr = 4'd15; cw_data = 32'hDEAD_BEEF;
    @(negedge clk); cw_addr = 4'd0; cw_data = 32'h0000_0001;
    @(negedge clk); cw_en = 0;
    read_creg(4'd15, c);  check("R9 creg 15", 64'(c), 64'hDEAD_BEEF);
    read_creg(4'd0, c);   check("R9 creg 0", 64'(c), 64'h1);
    read_creg(4'd7, c);   check("R9 creg untouched", 64'(c), 64'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule